// File: doc/BRIEF.md
# LPI Pending Table Priority Scanner

This block serves one redistributor. It finds the highest-priority pending message-signalled interrupt, where interrupt IDs start at 8192. A pulse on `start` begins a walk through the pending bitmap, which sits in external memory with one bit per interrupt ID. For every set bit in the LPI range, the block reads that ID's one-byte configuration entry from a second table. If the entry is enabled, its priority is derived and compared with a running best candidate.

A scan runs only when LPIs are enabled and both table base addresses are nonzero. The span of IDs comes from the programmed ID-width field, limited by a fixed implementation maximum. The best candidate is reported as an ID, a priority and a group. A one-cycle `done` pulse marks the end of the scan.

Memory is reached through a simple byte-wide read port with at most one request outstanding. Writing the tables and delivering the interrupt onward are left to neighbouring logic.

Top module: `lpi_pend_scan`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `best_valid` are 0, `best_prio` is 0xFF and `best_grp` is 2'b00.
- R2: If `start` arrives while `lpi_en` is 0, or while either base address is zero, no memory read is issued. `done` pulses in the cycle after `start`, and the best-candidate outputs keep their previous values.
- R3: Let W be the smaller of `id_bits` and IDBITS_MAX. A qualified scan reads pending bytes at `pend_base`+k, for k rising by one from LPI_BASE/8 up to 2^(W+1)/8−1. When that range is empty, no pending byte is read.
- R4: For each set bit of a pending byte, taken from bit 0 upward, the configuration byte of ID n = 8·k + bit is read at `cfg_base` + (n − LPI_BASE). An ID whose configuration bit 0 (enable) is 0 is ignored.
- R5: The priority field is the configuration byte ANDed with 0xFC. With `sec_dis` = 1 the effective priority is that field. With `sec_dis` = 0 it is (field >> 1) | 0x80.
- R6: A qualified scan first resets the best priority to 0xFF and `best_valid` to 0. A candidate then wins if its priority value is lower than the best so far; on an equal value, the lower ID is kept. `best_valid` is 1 exactly when some enabled pending ID was found.
- R7: `best_grp` is 2'b10 (non-secure group 1) while `best_valid` is 1, and 2'b00 otherwise. The code 2'b01 means secure group 1 and is never produced.
- R8: `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_rvalid` is high, which completes the read. Only one read is ever outstanding.
- R9: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` is high.
- R10: A `start` pulse while `busy` is high has no effect: no reads are added and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan request pulse |
| lpi_en | input | 1 | LPI enable |
| sec_dis | input | 1 | Security disabled: use the raw priority field |
| cfg_base | input | ADDR_W | Configuration table base address |
| pend_base | input | ADDR_W | Pending bitmap base address |
| id_bits | input | IDB_W | Programmed ID-width field |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8 | Read response byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| best_valid | output | 1 | A candidate was found |
| best_id | output | IDBITS_MAX+1 | Winning interrupt ID |
| best_prio | output | 8 | Winning effective priority |
| best_grp | output | 2 | Winning group code |

## Verification
A fault in the byte counter or the end-of-range limit appears on `mem_addr` within a few cycles. It shows as a gap, a repeat or a stray read, and later as a wrong count of pending reads before `done`. A wrong bit index or a bad clear of the held pending byte shows up as a configuration read for an ID whose pending bit is 0, or as a missed or repeated read. A fault in the comparator or the priority mapping is hidden until `done`, where `best_id` or `best_prio` differs from the value the bench model expects. Ties, the first and last IDs of the range, and disabled entries with strong priorities are placed so that such faults are exposed.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PEND = 3'd1,
      ST_PICK = 3'd2,
      ST_CFG  = 3'd3,
      ST_FIN  = 3'd4
   } scan_state_t;

   typedef enum logic [1:0] {
      GRP_G0      = 2'b00,
      GRP_G1_SEC  = 2'b01,
      GRP_G1_NSEC = 2'b10
   } lpi_grp_t;

   localparam logic [7:0] PRIO_IDLE    = 8'hFF;
   localparam logic [7:0] PRIO_FIELD   = 8'hFC;
   localparam logic [7:0] SEC_PRIO_TOP = 8'h80;
   localparam int         CFG_EN_POS   = 0;

endpackage

// File: rtl/lpi_prio_map.sv
module lpi_prio_map
   import lpi_scan_pkg::*;
(
   input  logic [7:0] cfg_byte,
   input  logic       sec_dis,
   output logic       entry_en,
   output logic [7:0] eff_prio
);

   logic [7:0] field;

   always_comb begin
      field    = cfg_byte & PRIO_FIELD;
      entry_en = cfg_byte[CFG_EN_POS];
      if (sec_dis) eff_prio = field;
      else         eff_prio = (field >> 1) | SEC_PRIO_TOP;
   end

endmodule

// File: rtl/lpi_low_bit.sv
module lpi_low_bit #(
   parameter int W     = 8,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   logic [W-1:0] first;

   for (genvar i = 0; i < W; i++) begin : g_first
      if (i == 0) begin : g_lsb
         assign first[i] = vec[0];
      end else begin : g_up
         assign first[i] = vec[i] & ~(|vec[i-1:0]);
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (first[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/lpi_best_cmp.sv
module lpi_best_cmp #(
   parameter int ID_W   = 16,
   parameter int PRIO_W = 8
) (
   input  logic              cand_ok,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [ID_W-1:0]   best_id,
   input  logic [PRIO_W-1:0] best_prio,
   output logic              take
);

   logic lower;
   logic tie_win;

   always_comb begin
      lower   = cand_prio < best_prio;
      tie_win = (cand_prio == best_prio) && (cand_id <= best_id);
      take    = cand_ok && (lower || tie_win);
   end

endmodule

// File: rtl/lpi_pend_scan.sv
module lpi_pend_scan
   import lpi_scan_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDB_W      = 5,
   parameter int IDBITS_MAX = 15,
   parameter int LPI_BASE   = 8192,
   localparam int ID_W      = IDBITS_MAX + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              lpi_en,
   input  logic              sec_dis,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] pend_base,
   input  logic [IDB_W-1:0]  id_bits,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              best_valid,
   output logic [ID_W-1:0]   best_id,
   output logic [7:0]        best_prio,
   output logic [1:0]        best_grp
);

   localparam int END_W      = ID_W - 2;
   localparam int START_BYTE = LPI_BASE / 8;
   localparam logic [END_W-1:0] START_IDX = END_W'(START_BYTE);
   localparam logic [IDB_W-1:0] IDB_CAP   = IDB_W'(IDBITS_MAX);

   if (LPI_BASE % 8 != 0) begin : g_bad_align
      $error("LPI_BASE must be a multiple of 8");
   end
   if (IDBITS_MAX < 3) begin : g_bad_small
      $error("IDBITS_MAX must be at least 3");
   end
   if (IDBITS_MAX >= (1 << IDB_W)) begin : g_bad_field
      $error("IDBITS_MAX does not fit the id_bits field");
   end
   if (LPI_BASE >= (1 << ID_W)) begin : g_bad_base
      $error("LPI_BASE lies beyond the ID space");
   end
   if (ADDR_W < ID_W) begin : g_bad_addr
      $error("ADDR_W narrower than the ID space");
   end

   scan_state_t       state_q;
   logic [END_W-1:0]  byte_q;
   logic [END_W-1:0]  end_q;
   logic [ADDR_W-1:0] pbase_q;
   logic [ADDR_W-1:0] cbase_q;
   logic              sec_q;
   logic [7:0]        pend_q;
   logic [2:0]        bit_q;
   logic              vld_q;
   logic [ID_W-1:0]   bid_q;
   logic [7:0]        bprio_q;
   logic [1:0]        bgrp_q;

   logic [IDB_W-1:0]  idb_eff;
   logic [IDB_W:0]    shift_amt;
   logic [ID_W:0]     id_span;
   logic [END_W-1:0]  end_calc;
   logic              eligible;
   logic              range_ok;
   logic [END_W-1:0]  byte_nx;
   logic              last_byte;
   logic [ID_W-1:0]   cur_id;
   logic [ADDR_W-1:0] cfg_addr;
   logic [ADDR_W-1:0] pend_addr;

   logic              low_any;
   logic [2:0]        low_idx;
   logic              ent_en;
   logic [7:0]        ent_prio;
   logic              cand_take;

   always_comb begin
      idb_eff   = (id_bits > IDB_CAP) ? IDB_CAP : id_bits;
      shift_amt = {1'b0, idb_eff} + 1'b1;
      id_span   = (ID_W + 1)'(1) << shift_amt;
      end_calc  = id_span[ID_W:3];
      eligible  = lpi_en && (cfg_base != '0) && (pend_base != '0);
      range_ok  = START_IDX < end_calc;
      byte_nx   = byte_q + 1'b1;
      last_byte = byte_nx == end_q;
      cur_id    = {byte_q[ID_W-4:0], bit_q};
      cfg_addr  = cbase_q + ADDR_W'(cur_id) - ADDR_W'(LPI_BASE);
      pend_addr = pbase_q + ADDR_W'(byte_q);
   end

   lpi_low_bit #(.W(8)) u_low (
      .vec (pend_q),
      .any (low_any),
      .idx (low_idx)
   );

   lpi_prio_map u_map (
      .cfg_byte (mem_rdata),
      .sec_dis  (sec_q),
      .entry_en (ent_en),
      .eff_prio (ent_prio)
   );

   lpi_best_cmp #(.ID_W(ID_W), .PRIO_W(8)) u_cmp (
      .cand_ok   (ent_en),
      .cand_id   (cur_id),
      .cand_prio (ent_prio),
      .best_id   (bid_q),
      .best_prio (bprio_q),
      .take      (cand_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         byte_q  <= '0;
         end_q   <= '0;
         pbase_q <= '0;
         cbase_q <= '0;
         sec_q   <= 1'b0;
         pend_q  <= '0;
         bit_q   <= '0;
         vld_q   <= 1'b0;
         bid_q   <= '1;
         bprio_q <= PRIO_IDLE;
         bgrp_q  <= GRP_G0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (eligible) begin
                     byte_q  <= START_IDX;
                     end_q   <= end_calc;
                     pbase_q <= pend_base;
                     cbase_q <= cfg_base;
                     sec_q   <= sec_dis;
                     vld_q   <= 1'b0;
                     bid_q   <= '1;
                     bprio_q <= PRIO_IDLE;
                     bgrp_q  <= GRP_G0;
                     state_q <= range_ok ? ST_PEND : ST_FIN;
                  end else begin
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_PEND: begin
               if (mem_rvalid) begin
                  pend_q  <= mem_rdata;
                  state_q <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (low_any) begin
                  bit_q   <= low_idx;
                  state_q <= ST_CFG;
               end else begin
                  byte_q  <= byte_nx;
                  state_q <= last_byte ? ST_FIN : ST_PEND;
               end
            end
            ST_CFG: begin
               if (mem_rvalid) begin
                  pend_q[bit_q] <= 1'b0;
                  if (cand_take) begin
                     vld_q   <= 1'b1;
                     bid_q   <= cur_id;
                     bprio_q <= ent_prio;
                     bgrp_q  <= GRP_G1_NSEC;
                  end
                  state_q <= ST_PICK;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = (state_q == ST_PEND) || (state_q == ST_CFG);
   assign mem_addr   = (state_q == ST_CFG) ? cfg_addr : pend_addr;
   assign busy       = state_q != ST_IDLE;
   assign done       = state_q == ST_FIN;
   assign best_valid = vld_q;
   assign best_id    = bid_q;
   assign best_prio  = bprio_q;
   assign best_grp   = bgrp_q;

endmodule

// File: rtl/lpi_pend_scan_chk.sv
module lpi_pend_scan_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              busy,
   input logic              done,
   input logic              best_valid,
   input logic [7:0]        best_prio,
   input logic [1:0]        best_grp
);

   assert_req_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_start_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_grp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      best_valid ? (best_grp == 2'b10) : (best_grp == 2'b00));

   assert_prio_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      best_valid |-> !best_prio[0]);

   assert_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !best_valid |-> (best_prio == 8'hFF));

endmodule

bind lpi_pend_scan lpi_pend_scan_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .busy       (busy),
   .done       (done),
   .best_valid (best_valid),
   .best_prio  (best_prio),
   .best_grp   (best_grp)
);

// File: tb/lpi_pend_scan_bench.sv
`timescale 1ns/1ps
module lpi_pend_scan_bench;

   localparam int ADDR_W      = 32;
   localparam int IDB_W       = 5;
   localparam int IDBITS_MAX  = 13;
   localparam int ID_W        = IDBITS_MAX + 1;
   localparam int LPI_BASE    = 8192;
   localparam int PEND_BYTES  = 2048;
   localparam int CFG_ENTRIES = 8192;
   localparam int TMO         = 60000;
   localparam logic [31:0] PB = 32'h0001_0000;
   localparam logic [31:0] CB = 32'h0004_0000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start;
   logic              lpi_en;
   logic              sec_dis;
   logic [ADDR_W-1:0] cfg_base;
   logic [ADDR_W-1:0] pend_base;
   logic [IDB_W-1:0]  id_bits;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_rvalid;
   logic [7:0]        mem_rdata;
   logic              busy;
   logic              done;
   logic              best_valid;
   logic [ID_W-1:0]   best_id;
   logic [7:0]        best_prio;
   logic [1:0]        best_grp;

   logic [7:0] pend_mem [PEND_BYTES];
   logic [7:0] cfg_mem  [CFG_ENTRIES];

   int n_cmp = 0;
   int n_bad = 0;
   int rd_pend, rd_cfg, rd_stray, rd_order_bad;
   int first_pend, last_pend, last_cfg_id;
   int lat;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lpi_pend_scan #(
      .ADDR_W(ADDR_W), .IDB_W(IDB_W), .IDBITS_MAX(IDBITS_MAX), .LPI_BASE(LPI_BASE)
   ) u_lpi_pend_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .lpi_en(lpi_en), .sec_dis(sec_dis),
      .cfg_base(cfg_base), .pend_base(pend_base), .id_bits(id_bits),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .best_valid(best_valid),
      .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic serve(input logic [31:0] a, output logic [7:0] d);
      int off;
      int id;
      if (a >= PB && a < PB + PEND_BYTES) begin
         off = int'(a - PB);
         d = pend_mem[off];
         rd_pend++;
         if (rd_pend == 1) first_pend = off;
         else if (off != last_pend + 1) rd_order_bad++;
         last_pend = off;
      end else if (a >= CB && a < CB + CFG_ENTRIES) begin
         off = int'(a - CB);
         d = cfg_mem[off];
         rd_cfg++;
         id = off + LPI_BASE;
         if (!pend_mem[id / 8][id % 8] || id <= last_cfg_id || (id / 8) != last_pend)
            rd_order_bad++;
         last_cfg_id = id;
      end else begin
         d = 8'h00;
         rd_stray++;
      end
   endtask

   // memory model: variable latency, one response per request
   initial begin
      logic [7:0] d;
      mem_rvalid = 1'b0;
      mem_rdata  = 8'h00;
      lat        = 0;
      forever begin
         @(negedge clk);
         if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            lat = int'($urandom % 3);
         end else if (mem_req) begin
            if (lat == 0) begin
               serve(mem_addr, d);
               mem_rdata  = d;
               mem_rvalid = 1'b1;
            end else begin
               lat--;
            end
         end
      end
   end

   task automatic model(input bit sec, input int idb, output bit v, output int bid,
                        output int bpr, output int npend, output int ncfg);
      int eff;
      int endb;
      int p;
      int id;
      logic [7:0] c;
      eff   = (idb > IDBITS_MAX) ? IDBITS_MAX : idb;
      endb  = (1 << (eff + 1)) / 8;
      v     = 1'b0;
      bid   = (1 << ID_W) - 1;
      bpr   = 255;
      ncfg  = 0;
      npend = (endb > LPI_BASE / 8) ? endb - LPI_BASE / 8 : 0;
      for (int b = LPI_BASE / 8; b < endb; b++) begin
         for (int k = 0; k < 8; k++) begin
            if (pend_mem[b][k]) begin
               id = b * 8 + k;
               ncfg++;
               c = cfg_mem[id - LPI_BASE];
               if (c[0]) begin
                  p = sec ? int'(c & 8'hFC) : (int'(c & 8'hFC) >> 1) | 8'h80;
                  if (p < bpr || (p == bpr && id <= bid)) begin
                     v = 1'b1; bid = id; bpr = p;
                  end
               end
            end
         end
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < PEND_BYTES; i++) pend_mem[i] = 8'h00;
      for (int i = 0; i < CFG_ENTRIES; i++) cfg_mem[i] = 8'h00;
   endtask

   task automatic fill_random();
      for (int i = 0; i < PEND_BYTES; i++)
         pend_mem[i] = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
      for (int i = 0; i < CFG_ENTRIES; i++) cfg_mem[i] = 8'($urandom);
   endtask

   task automatic set_pend(input int id, input logic [7:0] cfg);
      pend_mem[id / 8][id % 8] = 1'b1;
      cfg_mem[id - LPI_BASE] = cfg;
   endtask

   task automatic run_scan(input bit en, input bit sec, input int idb,
                           input logic [31:0] pbv, input logic [31:0] cbv,
                           input int mid_start, input string tag);
      bit   elig;
      bit   ev;
      int   eid, epr, npend, ncfg, n;
      logic pv;
      logic [ID_W-1:0] pid;
      logic [7:0] ppr;
      logic [1:0] pgr;
      @(negedge clk);
      lpi_en = en; sec_dis = sec; id_bits = IDB_W'(idb);
      pend_base = pbv; cfg_base = cbv;
      rd_pend = 0; rd_cfg = 0; rd_stray = 0; rd_order_bad = 0;
      first_pend = -1; last_pend = -10; last_cfg_id = -1;
      elig = en && pbv != 0 && cbv != 0;
      model(sec, idb, ev, eid, epr, npend, ncfg);
      pv = best_valid; pid = best_id; ppr = best_prio; pgr = best_grp;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
      n = 0;
      while (!done && n < TMO) begin
         @(negedge clk);
         n++;
         if (mid_start > 0 && n == mid_start) start = 1'b1;
         if (mid_start > 0 && n == mid_start + 1) start = 1'b0;
      end
      chk(n < TMO, {tag, " scan timeout"}, n, TMO);
      if (elig) begin
         chk(best_valid == ev, {tag, " R6 best_valid"}, best_valid, ev);
         if (ev) begin
            chk(best_id == ID_W'(eid), {tag, " R6 best_id"}, best_id, eid);
            chk(best_prio == 8'(epr), {tag, " R5 best_prio"}, best_prio, epr);
            chk(best_grp == 2'b10, {tag, " R7 group"}, best_grp, 2'b10);
         end else begin
            chk(best_prio == 8'hFF, {tag, " R6 idle prio"}, best_prio, 8'hFF);
            chk(best_grp == 2'b00, {tag, " R7 idle group"}, best_grp, 0);
         end
         chk(rd_pend == npend, {tag, " R3 pending read count"}, rd_pend, npend);
         if (npend > 0)
            chk(first_pend == LPI_BASE / 8, {tag, " R3 first byte"}, first_pend, LPI_BASE / 8);
         chk(rd_cfg == ncfg, {tag, " R4 config read count"}, rd_cfg, ncfg);
         chk(rd_order_bad == 0 && rd_stray == 0, {tag, " R4 read order"},
             rd_order_bad + rd_stray, 0);
         if (mid_start > 0)
            chk(rd_pend == npend && rd_cfg == ncfg, {tag, " R10 restart ignored"},
                rd_pend + rd_cfg, npend + ncfg);
      end else begin
         chk(n == 0, {tag, " R2 done latency"}, n, 0);
         chk(rd_pend + rd_cfg + rd_stray == 0, {tag, " R2 no reads"},
             rd_pend + rd_cfg + rd_stray, 0);
         chk(best_valid == pv && best_id == pid && best_prio == ppr && best_grp == pgr,
             {tag, " R2 outputs kept"}, {best_valid, best_id, best_prio},
             {pv, pid, ppr});
      end
      @(negedge clk);
      chk(!done && !busy, {tag, " R9 done single cycle"}, {done, busy}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; lpi_en = 1'b0; sec_dis = 1'b0;
      cfg_base = '0; pend_base = '0; id_bits = '0;
      clear_mem();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req, "R1 idle outputs", {busy, done, mem_req}, 0);
      chk(!best_valid, "R1 best_valid", best_valid, 0);
      chk(best_prio == 8'hFF, "R1 best_prio", best_prio, 8'hFF);
      chk(best_grp == 2'b00, "R1 best_grp", best_grp, 0);

      // R5 mapping of one entry, both security modes
      set_pend(8200, 8'h55);
      run_scan(1, 1, 13, PB, CB, 0, "R5 open");
      chk(best_prio == 8'h54, "R5 open prio", best_prio, 8'h54);
      run_scan(1, 0, 13, PB, CB, 0, "R5 secure");
      chk(best_prio == 8'hAA, "R5 secure prio", best_prio, 8'hAA);

      // R6 tie toward lower ID, R4 disabled entry ignored, bytes below range unread
      clear_mem();
      set_pend(9000, 8'h41);
      set_pend(8300, 8'h41);
      set_pend(9500, 8'h81);
      set_pend(8400, 8'h00);
      pend_mem[5] = 8'hFF;
      run_scan(1, 1, 13, PB, CB, 0, "R6 tie");
      chk(best_id == ID_W'(8300), "R6 tie winner", best_id, 8300);

      // boundary IDs of the range
      clear_mem();
      set_pend(8192, 8'h21);
      set_pend(16383, 8'h11);
      run_scan(1, 1, 13, PB, CB, 0, "R4 last id");
      chk(best_id == ID_W'(16383), "R4 last id wins", best_id, 16383);
      cfg_mem[0] = 8'h09;
      run_scan(1, 0, 13, PB, CB, 0, "R4 first id");
      chk(best_id == ID_W'(8192), "R4 first id wins", best_id, 8192);

      // ineligible starts keep the previous result
      run_scan(0, 1, 13, PB, CB, 0, "R2 disabled");
      run_scan(1, 1, 13, 32'h0, CB, 0, "R2 no pend base");
      run_scan(1, 1, 13, PB, 32'h0, 0, "R2 no cfg base");

      // nothing pending, empty range, clamped width
      clear_mem();
      run_scan(1, 0, 13, PB, CB, 0, "R6 empty");
      fill_random();
      run_scan(1, 0, 12, PB, CB, 0, "R3 empty range");
      chk(rd_pend == 0, "R3 no pending reads", rd_pend, 0);
      run_scan(1, 1, 20, PB, CB, 0, "R3 clamp");
      chk(rd_pend == 1024, "R3 clamped span", rd_pend, 1024);

      // start while busy
      run_scan(1, 0, 13, PB, CB, 40, "R10 mid start");

      // random contents
      for (int r = 0; r < 6; r++) begin
         fill_random();
         run_scan(1, r[0], 13, PB, CB, 0, "R6 random");
      end

      finish_up();
   end

endmodule